// File: doc/BRIEF.md
# Dual-Priority Self-Routing Switch Element

This block is one 2x2 switching cell of a self-routing multistage fabric. Each of its two input links feeds two single-slot buffers, one per traffic class. The header priority bit picks which buffer an arriving packet lands in. One bit of the destination tag, chosen by the stage index parameter, steers the packet to the upper output (bit 0) or the lower output (bit 1). The packet is a priority bit, a destination tag and a payload.

Every cycle has two phases. First, per-class readiness flows back: the next stage reports on `out_rdy_hi` / `out_rdy_lo` whether its buffer for that class can take a packet. The cell combines this with its own grants and reports per-class readiness upstream on `in_rdy_hi` / `in_rdy_lo`. Second, packets move on the clock edge.

Each output has its own weighted class scheduler. When both classes are eligible, it serves them in a fixed frame of high and low grants. When only one class is eligible, it serves that class. Two same-class packets from both inputs that want one output are settled by a pseudo-random coin, and the loser waits. Used as a first stage, an upstream source that ignores readiness simply loses packets that find their slot occupied. Used as a last stage, downstream readiness is ignored.

Top module: `dp_switch_elem`

## Requirements
- R1: A stored packet leaves on output `o` only when bit `STAGE_IDX` of its tag equals `o` (0 = upper output 0, 1 = lower output 1).
- R2: `in_pri` = 1 marks high priority and 0 marks low. Each input has one high slot and one low slot, and these are independent: a held high packet does not stop a low packet to the same output.
- R3: `in_rdy_hi[i]` / `in_rdy_lo[i]` are 1 exactly when that class slot of input `i` is empty or is departing this cycle. A packet presented while its slot is not ready is discarded, and the slot content is unchanged.
- R4: A packet of a class whose downstream ready bit for its output is 0 is held. It leaves later with unchanged tag and data.
- R5: A packet accepted at a clock edge can appear on its output in the cycle that follows that edge.
- R6: With both classes eligible at an output, grants follow a frame of `HI_SLOTS` high grants then `LO_SLOTS` low grants. Every grant at that output advances the frame, and the frame restarts on high after reset.
- R7: If only one class is eligible at an output, that class is granted in that cycle, whatever the frame position.
- R8: When both inputs hold an eligible packet of the granted class for the same output, exactly one is forwarded per cycle, and the other follows in the next cycle.
- R9: A slot departing in a cycle accepts a new packet in that same cycle. The new packet is the one held afterwards.
- R10: With `LAST_STAGE` = 1, packets leave regardless of `out_rdy_hi` / `out_rdy_lo`.
- R11: After reset all slots are empty, `out_valid` is 0, and every `in_rdy_*` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Packet present on input i |
| in_pri | input | 2 | Priority bit per input, 1 = high |
| in_tag | input | 2*TAG_W | Destination tag per input, input i at bits [i*TAG_W +: TAG_W] |
| in_data | input | 2*PAY_W | Payload per input |
| in_rdy_hi | output | 2 | High slot of input i can accept this cycle |
| in_rdy_lo | output | 2 | Low slot of input i can accept this cycle |
| out_rdy_hi | input | 2 | Next stage high buffer behind output o has room |
| out_rdy_lo | input | 2 | Next stage low buffer behind output o has room |
| out_valid | output | 2 | A packet moves out on output o this cycle |
| out_pri | output | 2 | Class of the packet on output o |
| out_tag | output | 2*TAG_W | Tag of the packet on output o |
| out_data | output | 2*PAY_W | Payload of the packet on output o |

## Verification
The assertions watch several properties every cycle. They check that no slot is written while it is occupied and not departing, and that a held slot keeps its packet. They check that a grant only goes to a requesting slot whose downstream class has room, that an output never idles while some class is eligible, and that every departing packet's tag bit matches its output. Some behaviours can only be shown by the bench's scenarios: the exact high/low grant pattern of the frame, discard of an arrival at a full slot, same-cycle refill, class independence under backpressure, the one-cycle latency, and last-stage operation.

// File: rtl/dpse_pkg.sv
// Package for the dual-priority switch element.
// Holds the class indices shared by the top and its submodules.
package dpse_pkg;
    localparam int CLS_LO = 0;
    localparam int CLS_HI = 1;
    localparam int NPORT  = 2;
endpackage

// File: rtl/dpse_slot.sv
// Single-slot packet buffer for one traffic class of one input link.
// Assumes the writer only writes when the slot is empty or departing,
// and that reads (departures) only happen on an occupied slot.
module dpse_slot #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_pkt,
    input  logic         rd,
    output logic         full,
    output logic [W-1:0] pkt
);
    // Occupancy flag: set by a write, cleared by a departure without refill.
    always_ff @(posedge clk) begin
        if (!rst_n)    full <= 1'b0;
        else if (wr)   full <= 1'b1;
        else if (rd)   full <= 1'b0;
    end

    // Payload register: captures the arriving packet, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)  pkt <= '0;
        else if (wr) pkt <= wr_pkt;
    end

    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (!full || rd));
    assert_rd_needs_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> full);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd && !wr) |=> (full && $stable(pkt)));
endmodule

// File: rtl/dpse_lfsr.sv
// Free-running Fibonacci LFSR supplying coin bits for same-class contention.
// Assumes SEED is non-zero.
module dpse_lfsr #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  TAPS = 8'hB8,
    parameter logic [W-1:0]  SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Shift in the parity of the tapped bits every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], ^(state & TAPS)};
    end

    assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/dpse_class_sched.sv
// Per-output weighted class scheduler and input arbiter.
// Eligible class = some input requests it and downstream has room (or last
// stage). A frame of HI_SLOTS+LO_SLOTS grants sets the preferred class; the
// other eligible class is served when the preferred one is not (work
// conserving). Two same-class requesters are split by the coin bit.
module dpse_class_sched #(
    parameter int HI_SLOTS   = 3,
    parameter int LO_SLOTS   = 1,
    parameter bit LAST_STAGE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_hi,
    input  logic [1:0] req_lo,
    input  logic       rdy_hi,
    input  logic       rdy_lo,
    input  logic       coin,
    output logic       gnt_valid,
    output logic       gnt_hi,
    output logic       gnt_in
);
    localparam int TOT = HI_SLOTS + LO_SLOTS;
    localparam int CW  = (TOT > 2) ? $clog2(TOT) : 1;

    logic [CW-1:0] frame_q;
    logic          ok_hi, ok_lo, pref_hi;
    logic [1:0]    req_sel;

    // Class eligibility, frame preference and the resulting grant.
    always_comb begin
        ok_hi   = (|req_hi) && (LAST_STAGE || rdy_hi);
        ok_lo   = (|req_lo) && (LAST_STAGE || rdy_lo);
        pref_hi = (frame_q < CW'(HI_SLOTS));
        gnt_valid = ok_hi || ok_lo;
        gnt_hi    = pref_hi ? ok_hi : !ok_lo;
        req_sel   = gnt_hi ? req_hi : req_lo;
        gnt_in    = (req_sel == 2'b11) ? coin : req_sel[1];
    end

    // Frame position: advances on every grant, wraps after TOT grants.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else if (gnt_valid)
            frame_q <= (frame_q == CW'(TOT - 1)) ? '0 : frame_q + 1'b1;
    end

    assert_grant_has_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (LAST_STAGE || (gnt_hi ? rdy_hi : rdy_lo)));
    assert_work_conserving_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_hi && (LAST_STAGE || rdy_hi)) || (|req_lo && (LAST_STAGE || rdy_lo)))
            |-> gnt_valid);
    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_hi ? req_hi[gnt_in] : req_lo[gnt_in]));
endmodule

// File: rtl/dp_switch_elem.sv
// Dual-priority 2x2 self-routing switch element for one fabric stage.
// Per input: one high and one low single-slot buffer. Per output: a weighted
// class scheduler. Readiness to upstream is combinational on downstream
// readiness (backward phase); slots update on the clock edge (forward phase).
// Assumes STAGE_IDX < TAG_W.
module dp_switch_elem #(
    parameter int TAG_W      = 3,
    parameter int PAY_W      = 16,
    parameter int STAGE_IDX  = 1,
    parameter int HI_SLOTS   = 3,
    parameter int LO_SLOTS   = 1,
    parameter bit LAST_STAGE = 1'b0,
    parameter int LFSR_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         in_valid,
    input  logic [1:0]         in_pri,
    input  logic [2*TAG_W-1:0] in_tag,
    input  logic [2*PAY_W-1:0] in_data,
    output logic [1:0]         in_rdy_hi,
    output logic [1:0]         in_rdy_lo,
    input  logic [1:0]         out_rdy_hi,
    input  logic [1:0]         out_rdy_lo,
    output logic [1:0]         out_valid,
    output logic [1:0]         out_pri,
    output logic [2*TAG_W-1:0] out_tag,
    output logic [2*PAY_W-1:0] out_data
);
    import dpse_pkg::*;

    localparam int SLOT_W  = TAG_W + PAY_W;
    localparam int ROUTE_B = PAY_W + STAGE_IDX;

    logic [SLOT_W-1:0] slot_q  [NPORT][2];
    logic              full    [NPORT][2];
    logic              wr      [NPORT][2];
    logic              depart  [NPORT][2];
    logic [1:0]        gv, gh, gi;
    logic [1:0]        req_hi_o [NPORT];
    logic [1:0]        req_lo_o [NPORT];
    logic [LFSR_W-1:0] lfsr_q;

    dpse_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(8'hB8)), .SEED(LFSR_W'(8'h5A))) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state(lfsr_q)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        for (genvar c = 0; c < 2; c++) begin : g_cls
            // Write strobe: valid packet of this class while the slot is ready.
            always_comb begin
                wr[i][c] = in_valid[i] && (in_pri[i] == 1'(c))
                           && (!full[i][c] || depart[i][c]);
            end
            dpse_slot #(.W(SLOT_W)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .wr(wr[i][c]),
                .wr_pkt({in_tag[i*TAG_W +: TAG_W], in_data[i*PAY_W +: PAY_W]}),
                .rd(depart[i][c]),
                .full(full[i][c]),
                .pkt(slot_q[i][c])
            );
        end
        // Upstream readiness per class: empty or leaving this cycle.
        always_comb begin
            in_rdy_hi[i] = !full[i][CLS_HI] || depart[i][CLS_HI];
            in_rdy_lo[i] = !full[i][CLS_LO] || depart[i][CLS_LO];
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        // Requests toward this output: occupied slots whose route bit matches.
        always_comb begin
            for (int i = 0; i < NPORT; i++) begin
                req_hi_o[o][i] = full[i][CLS_HI] && (slot_q[i][CLS_HI][ROUTE_B] == 1'(o));
                req_lo_o[o][i] = full[i][CLS_LO] && (slot_q[i][CLS_LO][ROUTE_B] == 1'(o));
            end
        end
        dpse_class_sched #(.HI_SLOTS(HI_SLOTS), .LO_SLOTS(LO_SLOTS),
                           .LAST_STAGE(LAST_STAGE)) u_sched (
            .clk(clk), .rst_n(rst_n),
            .req_hi(req_hi_o[o]), .req_lo(req_lo_o[o]),
            .rdy_hi(out_rdy_hi[o]), .rdy_lo(out_rdy_lo[o]),
            .coin(lfsr_q[o]),
            .gnt_valid(gv[o]), .gnt_hi(gh[o]), .gnt_in(gi[o])
        );
        // Output mux: present the granted slot's packet.
        always_comb begin
            out_valid[o] = gv[o];
            out_pri[o]   = gh[o];
            {out_tag[o*TAG_W +: TAG_W], out_data[o*PAY_W +: PAY_W]} =
                slot_q[gi[o]][gh[o] ? CLS_HI : CLS_LO];
        end

        assert_route_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (out_tag[o*TAG_W + STAGE_IDX] == 1'(o)));
    end

    // Departure map: a slot leaves when any output grants its input and class.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int c = 0; c < 2; c++) begin
                depart[i][c] = 1'b0;
                for (int o = 0; o < NPORT; o++) begin
                    if (gv[o] && (gh[o] == 1'(c)) && (gi[o] == 1'(i)))
                        depart[i][c] = 1'b1;
                end
            end
        end
    end
endmodule

// File: tb/dp_switch_elem_bench.sv
`timescale 1ns/100ps
module dp_switch_elem_bench;
    localparam int TW = 3;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0] in_valid = '0, in_pri = '0, out_rdy_hi = '1, out_rdy_lo = '1;
    logic [2*TW-1:0] in_tag = '0;
    logic [2*PW-1:0] in_data = '0;
    logic [1:0] in_rdy_hi, in_rdy_lo, out_valid, out_pri;
    logic [2*TW-1:0] out_tag;
    logic [2*PW-1:0] out_data;

    logic [1:0] l_valid = '0, l_pri = '0, l_rh = '0, l_rl = '0;
    logic [2*TW-1:0] l_tag = '0;
    logic [2*PW-1:0] l_data = '0;
    logic [1:0] l_irh, l_irl, l_ov, l_opri;
    logic [2*TW-1:0] l_otag;
    logic [2*PW-1:0] l_odata;

    dp_switch_elem u_dp_switch_elem (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pri(in_pri),
        .in_tag(in_tag), .in_data(in_data), .in_rdy_hi(in_rdy_hi),
        .in_rdy_lo(in_rdy_lo), .out_rdy_hi(out_rdy_hi), .out_rdy_lo(out_rdy_lo),
        .out_valid(out_valid), .out_pri(out_pri), .out_tag(out_tag),
        .out_data(out_data));

    dp_switch_elem #(.STAGE_IDX(0), .LAST_STAGE(1'b1)) u_last (
        .clk(clk), .rst_n(rst_n), .in_valid(l_valid), .in_pri(l_pri),
        .in_tag(l_tag), .in_data(l_data), .in_rdy_hi(l_irh),
        .in_rdy_lo(l_irl), .out_rdy_hi(l_rh), .out_rdy_lo(l_rl),
        .out_valid(l_ov), .out_pri(l_opri), .out_tag(l_otag),
        .out_data(l_odata));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0] v, p;
        logic [2:0] t0, t1;
        logic [15:0] d0, d1;
        logic [1:0] rh, rl, eov;
        logic [15:0] eod0, eod1;
        logic [1:0] erh;
    } vec_t;

    // Rows are applied one cycle each; expectations hold in that same cycle.
    localparam vec_t VEC [7] = '{
        '{2'b11, 2'b01, 3'b000, 3'b010, 16'hA001, 16'hB001, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0, 2'b11},
        '{2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11, 2'b11, 16'hA001, 16'hB001, 2'b11},
        '{2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0, 2'b11},
        '{2'b01, 2'b01, 3'b010, 3'b000, 16'hA002, 16'h0, 2'b00, 2'b11, 2'b00, 16'h0, 16'h0, 2'b11},
        '{2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b00, 2'b11, 2'b00, 16'h0, 16'h0, 2'b10},
        '{2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11, 2'b10, 16'h0, 16'hA002, 2'b11},
        '{2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0, 2'b11}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and let the combinational paths settle.
    task automatic drive(input logic [1:0] v, p, input logic [2:0] t0, t1,
                         input logic [15:0] d0, d1, input logic [1:0] rh, rl);
        @(negedge clk);
        in_valid = v; in_pri = p; in_tag = {t1, t0}; in_data = {d1, d0};
        out_rdy_hi = rh; out_rdy_lo = rl;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = '0; l_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] first;
        do_reset();
        #1;
        // R11: reset state
        chk(out_valid == 2'b00, "R11 out_valid", 32'(out_valid), 0);
        chk(in_rdy_hi == 2'b11 && in_rdy_lo == 2'b11, "R11 ready",
            32'({in_rdy_hi, in_rdy_lo}), 32'hF);

        // Table walk: R1 routing, R5 latency, R4 hold, R7 lone low served, R3 ready.
        for (int r = 0; r < 7; r++) begin
            drive(VEC[r].v, VEC[r].p, VEC[r].t0, VEC[r].t1, VEC[r].d0, VEC[r].d1,
                  VEC[r].rh, VEC[r].rl);
            chk(out_valid == VEC[r].eov, $sformatf("R1 R4 R5 row %0d valid", r),
                32'(out_valid), 32'(VEC[r].eov));
            if (VEC[r].eov[0])
                chk(out_data[15:0] == VEC[r].eod0, $sformatf("R1 R5 row %0d out0", r),
                    32'(out_data[15:0]), 32'(VEC[r].eod0));
            if (VEC[r].eov[1])
                chk(out_data[31:16] == VEC[r].eod1, $sformatf("R1 R7 row %0d out1", r),
                    32'(out_data[31:16]), 32'(VEC[r].eod1));
            chk(in_rdy_hi == VEC[r].erh, $sformatf("R3 row %0d rdy_hi", r),
                32'(in_rdy_hi), 32'(VEC[r].erh));
        end

        // R2: held high packet does not stop low packet to the same output.
        do_reset();
        drive(2'b01, 2'b01, 3'b000, 3'b000, 16'hE001, 16'h0, 2'b00, 2'b11);
        drive(2'b01, 2'b00, 3'b000, 3'b000, 16'hE002, 16'h0, 2'b00, 2'b11);
        chk(out_valid == 2'b00, "R2 nothing yet", 32'(out_valid), 0);
        drive(2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b00, 2'b11);
        chk(out_valid[0] && !out_pri[0] && out_data[15:0] == 16'hE002, "R2 low passes",
            {out_valid, out_pri, out_data[15:0]}, {2'b01, 2'b00, 16'hE002});
        drive(2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11);
        chk(out_valid[0] && out_pri[0] && out_data[15:0] == 16'hE001, "R2 R4 high released",
            {out_valid, out_pri, out_data[15:0]}, {2'b01, 2'b01, 16'hE001});

        // R3 discard, R4 hold, R9 refill on departure.
        do_reset();
        drive(2'b01, 2'b01, 3'b000, 3'b000, 16'hD001, 16'h0, 2'b00, 2'b11);
        drive(2'b01, 2'b01, 3'b000, 3'b000, 16'hD002, 16'h0, 2'b00, 2'b11);
        chk(in_rdy_hi[0] == 1'b0, "R3 full slot not ready", 32'(in_rdy_hi), 32'h2);
        drive(2'b01, 2'b01, 3'b000, 3'b000, 16'hD003, 16'h0, 2'b11, 2'b11);
        chk(out_valid[0] && out_data[15:0] == 16'hD001, "R4 held packet unchanged",
            32'(out_data[15:0]), 32'hD001);
        chk(in_rdy_hi[0] == 1'b1, "R9 ready while departing", 32'(in_rdy_hi), 32'h3);
        drive(2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11);
        chk(out_valid[0] && out_data[15:0] == 16'hD003, "R9 refill held",
            32'(out_data[15:0]), 32'hD003);
        drive(2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11);
        chk(out_valid == 2'b00, "R3 discarded packet absent", 32'(out_valid), 0);

        // R8: same-class contention, one per cycle.
        do_reset();
        drive(2'b11, 2'b11, 3'b000, 3'b000, 16'hC001, 16'hC002, 2'b11, 2'b11);
        drive(2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11);
        first = out_data[15:0];
        chk(out_valid == 2'b01 && (first == 16'hC001 || first == 16'hC002),
            "R8 one winner", {out_valid, first}, 32'h1C001);
        chk($countones(in_rdy_hi) == 1, "R8 loser held", 32'(in_rdy_hi), 32'h1);
        drive(2'b00, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 2'b11, 2'b11);
        chk(out_valid == 2'b01 && out_data[15:0] == (first ^ 16'h0003), "R8 loser next",
            32'(out_data[15:0]), 32'(first ^ 16'h0003));

        // R6: weighted frame 3 high then 1 low with both classes eligible.
        do_reset();
        drive(2'b11, 2'b01, 3'b000, 3'b000, 16'hF000, 16'h7000, 2'b11, 2'b11);
        for (int k = 1; k <= 8; k++) begin
            drive(2'b11, 2'b01, 3'b000, 3'b000, 16'(16'hF000 + k), 16'h7000, 2'b11, 2'b11);
            chk(out_valid == 2'b01 && out_pri[0] == (((k - 1) % 4) != 3),
                $sformatf("R6 frame grant %0d", k), {out_valid, out_pri},
                {2'b01, 1'b0, 1'(((k - 1) % 4) != 3)});
        end

        // R10 + R1 on a last-stage element using tag bit 0.
        do_reset();
        @(negedge clk);
        in_valid = '0;
        l_valid = 2'b01; l_pri = 2'b01; l_tag = {3'b000, 3'b001};
        l_data = {16'h0, 16'h5A5A}; l_rh = 2'b00; l_rl = 2'b00;
        @(negedge clk);
        l_valid = '0;
        #1;
        chk(l_ov == 2'b10 && l_odata[31:16] == 16'h5A5A, "R10 R1 last stage",
            {l_ov, l_odata[31:16]}, {2'b10, 16'h5A5A});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule